// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating and Transceiver Enable

This block turns bytes into asynchronous serial frames on a single output line. It suits a half-duplex link where an external line transceiver must be switched on before the frame and switched off after it. Software or a neighbouring block writes a byte into a one-deep holding slot. The transmitter then raises a transceiver-enable output and waits a set-up interval. After that it shifts out a low start bit, eight data bits least significant first, an optional parity bit and a high stop bit. Each bit is timed by a one-cycle tick that an external baud generator supplies.

Flow control comes from a clear-to-send input. The block samples it only at the clock edge that would launch a new frame. A frame that has already begun always runs to its end. When a second byte arrives before the current frame finishes, the next start bit follows the stop bit with no gap, and the transceiver enable never drops. The enable output can be made active high or active low.

Top module: `sertx_de`

## Requirements
- R1: With `cts_en` high, a frame starts (start bit on `txd` in the cycle after a tick edge) only when `cts_ok` was high at that same tick edge, one clock before the start bit appears. Otherwise the byte is held, `txd` stays high, and the gate is tried again at each later tick.
- R2: Dropping `cts_ok` while a frame is on the line does not shorten or change that frame.
- R3: With `cts_en` low, `cts_ok` has no effect and a pending byte is always sent.
- R4: A write accepted while idle drives the enable active in the next cycle. Let P be the tick spacing in clocks. The start bit then appears more than P and at most 2P clock cycles after the enable first shows active.
- R5: The enable stays active for the whole frame. It is still active in the first clock after the tick that ends the stop bit, and goes inactive in the clock after that.
- R6: A byte written at least one clock before the stop bit ends (with clear-to-send allowed) starts its frame directly after that stop bit, and the enable stays active throughout.
- R7: With `de_act_low` = 0 the enable output is 1 when active and 0 when inactive. With `de_act_low` = 1 it is the other way round.
- R8: Frame format: `txd` idles at 1. A frame is a start bit of 0, then data bits 0 to 7 in that order, then a parity bit if `par_en` = 1, then a stop bit of 1. Parity is the XOR of the data bits when `par_odd` = 0 (even) and its inverse when `par_odd` = 1 (odd). Each bit lasts from one tick edge to the next.
- R9: `tx_empty` is 1 when the holding slot is free. It goes to 0 in the cycle after an accepted write and back to 1 in the cycle the start bit appears. `tx_busy` is 1 exactly while the enable is active.
- R10: A write while the holding slot is full is dropped. The held byte is sent unchanged.
- R11: After reset `txd` = 1, the enable is inactive, `tx_empty` = 1 and `tx_busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| wr_en | input | 1 | Write strobe for the holding slot |
| wr_data | input | DW | Byte to transmit |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_ok | input | 1 | Clear-to-send, 1 = peer ready |
| de_act_low | input | 1 | Enable output polarity, 1 = active low |
| txd | output | 1 | Serial data line |
| de | output | 1 | Transceiver enable |
| tx_empty | output | 1 | Holding slot can take a byte |
| tx_busy | output | 1 | Lead-in, frame or release in progress |

## Verification
The main function is swept over all 256 byte values under each of the three parity settings. The enable polarity alternates and the write phase rotates against the tick, so one sweep checks the bit order, the parity sense and the lead-in bounds at every phase. Separate runs cover back-to-back bytes, which expose any gap between frames or any enable drop, and writes into a full slot, which show whether the held byte is overwritten. The clear-to-send gate is tested by raising `cts_ok` just before and just after a tick edge. This tells a gate that samples at that edge apart from one that samples a cycle late. Dropping `cts_ok` in the middle of a frame tells a boundary-only gate apart from one that cuts frames short.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_GAP,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_TAIL
  } tx_state_e;

  // Number of bit periods in one frame.
  function automatic int unsigned frame_bits(input int unsigned dw, input logic pen);
    return dw + 2 + (pen ? 1 : 0);
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic          accept,
  output logic [DW-1:0] data
);

  assign accept = wr_en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          pend,
  input  logic          wr_accept,
  input  logic [DW-1:0] hold_data,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          cts_en,
  input  logic          cts_ok,
  output logic          load_evt,
  output logic          done_evt,
  output logic          block_evt,
  output logic          active,
  output logic          line
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  function automatic logic calc_parity(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  tx_state_e st_q, st_d;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] idx_q;
  logic          pen_q;
  logic          par_q;
  logic          go_ok;
  logic          at_boundary;

  assign go_ok       = !cts_en || cts_ok;
  assign at_boundary = (st_q == ST_GAP) || (st_q == ST_STOP);
  assign load_evt    = bit_tick && pend && go_ok && at_boundary;
  assign block_evt   = bit_tick && pend && !go_ok && at_boundary;
  assign done_evt    = bit_tick && (st_q == ST_STOP);
  assign active      = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (pend || wr_accept) st_d = ST_LEAD;
      ST_LEAD:  if (bit_tick) st_d = ST_GAP;
      ST_GAP:   if (load_evt) st_d = ST_START;
      ST_START: if (bit_tick) st_d = ST_DATA;
      ST_DATA:  if (bit_tick && idx_q == LAST_IDX) st_d = pen_q ? ST_PAR : ST_STOP;
      ST_PAR:   if (bit_tick) st_d = ST_STOP;
      ST_STOP: begin
        if (load_evt)       st_d = ST_START;
        else if (block_evt) st_d = ST_GAP;
        else if (bit_tick)  st_d = ST_TAIL;
      end
      ST_TAIL:  st_d = (pend || wr_accept) ? ST_LEAD : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      pen_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_evt) begin
        sh_q  <= hold_data;
        pen_q <= par_en;
        par_q <= calc_parity(hold_data, par_odd);
      end else if (bit_tick && st_q == ST_DATA) begin
        sh_q  <= sh_q >> 1;
        idx_q <= idx_q + 1'b1;
      end
      if (bit_tick && st_q == ST_START) idx_q <= '0;
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

endmodule

// File: rtl/sertx_pins.sv
module sertx_pins (
  input  logic active,
  input  logic line,
  input  logic de_act_low,
  output logic txd,
  output logic de,
  output logic busy
);

  assign txd  = line;
  assign de   = active ^ de_act_low;
  assign busy = active;

endmodule

// File: rtl/sertx_de.sv
module sertx_de #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          cts_en,
  input  logic          cts_ok,
  input  logic          de_act_low,
  output logic          txd,
  output logic          de,
  output logic          tx_empty,
  output logic          tx_busy
);

  logic          pend;
  logic          wr_accept;
  logic [DW-1:0] hold_q;
  logic          load_evt;
  logic          done_evt;
  logic          block_evt;
  logic          active;
  logic          line;

  sertx_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load_evt),
    .full    (pend),
    .accept  (wr_accept),
    .data    (hold_q)
  );

  sertx_engine #(.DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .pend      (pend),
    .wr_accept (wr_accept),
    .hold_data (hold_q),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .cts_en    (cts_en),
    .cts_ok    (cts_ok),
    .load_evt  (load_evt),
    .done_evt  (done_evt),
    .block_evt (block_evt),
    .active    (active),
    .line      (line)
  );

  sertx_pins u_pins (
    .active     (active),
    .line       (line),
    .de_act_low (de_act_low),
    .txd        (txd),
    .de         (de),
    .busy       (tx_busy)
  );

  assign tx_empty = !pend;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          wr_en,
  input logic          cts_en,
  input logic          cts_ok,
  input logic          de_act_low,
  input logic          txd,
  input logic          de,
  input logic          tx_empty,
  input logic          tx_busy,
  input logic          load_evt,
  input logic          done_evt,
  input logic          pend,
  input logic [DW-1:0] hold_q
);

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R5
  de_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> (de != de_act_low));

  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  // R1
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cts_en) |-> cts_ok);

  // R5
  de_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !pend) |=> (tx_busy && txd && de != de_act_low));

  // R10
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && wr_en && !load_evt) |=> (!tx_empty && $stable(hold_q)));

endmodule

bind sertx_de sertx_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_tick   (bit_tick),
  .wr_en      (wr_en),
  .cts_en     (cts_en),
  .cts_ok     (cts_ok),
  .de_act_low (de_act_low),
  .txd        (txd),
  .de         (de),
  .tx_empty   (tx_empty),
  .tx_busy    (tx_busy),
  .load_evt   (load_evt),
  .done_evt   (done_evt),
  .pend       (pend),
  .hold_q     (hold_q)
);

// File: tb/sertx_de_tb.sv
`timescale 1ns/1ps
module sertx_de_tb;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts_ok = 1'b1;
  logic       de_act_low = 1'b0;
  logic       txd, de, tx_empty, tx_busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tcnt = 0;
  bit done = 1'b0;

  sertx_de #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .par_en(par_en), .par_odd(par_odd), .cts_en(cts_en),
    .cts_ok(cts_ok), .de_act_low(de_act_low), .txd(txd), .de(de),
    .tx_empty(tx_empty), .tx_busy(tx_busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1) % P;
      bit_tick = (tcnt == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start(output int s);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (txd !== 1'b0 && n < 6 * P + 40);
    chk(txd === 1'b0, "R8", "start bit seen", txd, 0);
    s = cyc;
  endtask

  // Called at the negedge where the start bit is first visible.
  task automatic frame(input logic [7:0] b, input bit more);
    logic exp_bits [0:11];
    int nb = 10 + (par_en ? 1 : 0);
    int badbit = 0;
    int badde = 0;
    logic act = ~de_act_low;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) exp_bits[i+1] = b[i];
    exp_bits[9] = par_odd ? ~(^b) : (^b);
    exp_bits[nb-1] = 1'b1;
    for (int k = 0; k <= P * nb; k++) begin
      if (k > 0) @(negedge clk);
      if (de !== act) badde++;
      if (k < P * nb && (k % P) == P / 2 && txd !== exp_bits[k / P]) badbit++;
    end
    chk(badbit == 0, "R8", $sformatf("frame bits of %02h", b), badbit, 0);
    chk(badde == 0, "R5", "enable held across frame", badde, 0);
    if (!more) begin
      @(negedge clk);
      chk(de === de_act_low && tx_busy === 1'b0, "R5",
          "enable released one clock after stop", de, de_act_low);
    end
  endtask

  initial begin
    int s;
    int d;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(txd === 1'b1 && de === 1'b0 && tx_empty === 1'b1 && tx_busy === 1'b0,
        "R11", "reset outputs", {txd, de, tx_empty, tx_busy}, 4'b1010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep: all bytes, three parity modes, alternating polarity (R7, R8, R4, R9)
    for (int pm = 0; pm < 3; pm++) begin
      for (int b = 0; b < 256; b++) begin
        par_en = (pm != 0);
        par_odd = (pm == 2);
        de_act_low = b[0] ^ pm[0];
        repeat (b % P + 1) @(negedge clk);
        chk(de === de_act_low, "R7", "inactive enable level", de, de_act_low);
        wr(8'(b));
        d = cyc;
        chk(tx_empty === 1'b0 && tx_busy === 1'b1 && de === ~de_act_low, "R9",
            "flags and R4 enable after write", {tx_empty, tx_busy, de}, {2'b01, ~de_act_low});
        wait_start(s);
        chk((s - d) > P && (s - d) <= 2 * P, "R4", "lead-in cycles", s - d, 2 * P);
        chk(tx_empty === 1'b1, "R9", "empty at start bit", tx_empty, 1);
        frame(8'(b), 1'b0);
      end
    end

    // R6 back-to-back, active-low enable, even parity
    par_en = 1'b1; par_odd = 1'b0; de_act_low = 1'b1;
    wr(8'h3C);
    wait_start(s);
    fork
      begin
        repeat (P * 3) @(negedge clk);
        wr(8'hC5);
      end
    join_none
    frame(8'h3C, 1'b1);
    chk(txd === 1'b0, "R6", "second start follows stop", txd, 0);
    frame(8'hC5, 1'b0);

    // R3 gating disabled: cts_ok low has no effect
    par_en = 1'b0; de_act_low = 1'b0;
    cts_en = 1'b0; cts_ok = 1'b0;
    wr(8'h96);
    wait_start(s);
    frame(8'h96, 1'b0);

    // R1 late raise: misses the tick, start one period later
    cts_en = 1'b1; cts_ok = 1'b0;
    wr(8'h71);
    repeat (3 * P) @(negedge clk);
    chk(txd === 1'b1 && de === 1'b1, "R1", "held while blocked", {txd, de}, 2'b11);
    do begin @(negedge clk); #1; end while (bit_tick !== 1'b1);
    @(posedge clk); #1 cts_ok = 1'b1;
    repeat (P) @(negedge clk);
    chk(txd === 1'b1, "R1", "late raise not taken", txd, 1);
    @(negedge clk);
    chk(txd === 1'b0, "R1", "start at next tick", txd, 0);
    frame(8'h71, 1'b0);

    // R1 early raise: taken at this tick edge
    cts_ok = 1'b0;
    wr(8'h0E);
    repeat (3 * P) @(negedge clk);
    do begin @(negedge clk); #1; end while (bit_tick !== 1'b1);
    cts_ok = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R1", "raise before tick edge taken", txd, 0);
    frame(8'h0E, 1'b0);

    // R2 drop mid-frame: frame completes
    par_en = 1'b1; par_odd = 1'b1;
    wr(8'hE1);
    fork
      begin
        repeat (P * 4) @(negedge clk);
        cts_ok = 1'b0;
      end
    join_none
    wait_start(s);
    frame(8'hE1, 1'b0);
    chk(1'b1, "R2", "frame completed after drop", 0, 0);

    // R10 write while full is dropped
    cts_ok = 1'b0;
    wr(8'h5A);
    wr(8'hA7);
    chk(tx_empty === 1'b0, "R10", "slot still full", tx_empty, 0);
    repeat (P) @(negedge clk);
    cts_ok = 1'b1;
    wait_start(s);
    frame(8'h5A, 1'b0);
    repeat (4 * P) @(negedge clk);
    chk(tx_busy === 1'b0 && txd === 1'b1 && tx_empty === 1'b1, "R10",
        "no second frame", {tx_busy, txd, tx_empty}, 3'b011);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule